// File: doc/BRIEF.md
# Header-Addressed SPI Register Bridge

This block is an SPI target that sits between an external host and a byte-wide register or memory bus inside the chip. While chip select is low, the host sends a byte stream. The first byte is a header. Its top bit selects read (1) or write (0), and its low seven bits name a target. Only a target whose ID matches the `TARGET_ID` parameter answers. A fixed number of address bytes follows, set by `ADDR_BYTES` and sent most significant byte first. These form a start address. After that, the host either streams bytes to write, or clocks filler bytes to fetch read data.

The SPI inputs are synchronized into the system clock before their edges are detected, so SCLK must be well below the system clock rate. On a read, the block echoes the header during the first filler byte. It prefetches each data byte from the bus so that the byte is waiting in the shift register before its first bit is due. To read N data bytes, the host sends N+1 filler bytes. A burst has no length limit, and the address moves up by one per data byte. Releasing chip select returns the block to waiting for a header.

Top module: `spi_reg_bridge`

## Requirements
- R1: The SPI link uses mode 0 with MSB first. MOSI is sampled on rising SCLK and MISO changes after falling SCLK. In the first byte of a transaction, bit 7 is 1 for read and 0 for write, and bits 6:0 are the target ID.
- R2: When the header ID differs from `TARGET_ID`, the block makes no bus access and holds MISO at 0 until chip select is released.
- R3: The `ADDR_BYTES` bytes after the header form the start address, first byte most significant.
- R4: In a write, each byte after the address phase causes exactly one `busWrEn` pulse, with that byte on `busWdata`. The address starts at the start address and rises by one per byte.
- R5: In a read, the first byte shifted out after the address phase is the received header byte (flag and ID).
- R6: In a read, each later byte shifted out is the bus data for the start address, then the start address plus one, and so on. `busRdata` is sampled in the clock cycle after the `busRdEn` pulse.
- R7: A burst has no length limit, and the address carries across byte boundaries and wraps at the top of its range.
- R8: Releasing chip select at any point, including mid-address, discards the partial transaction. The next byte is then taken as a header.
- R9: MISO is 0 while chip select is high, and also during the header, address and write-data phases.
- R10: `busWrEn` and `busRdEn` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiSclk | input | 1 | SPI clock from the host, idle low |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host |
| busWrEn | output | 1 | Write strobe, one cycle |
| busRdEn | output | 1 | Read request, one cycle |
| busAddr | output | 8*ADDR_BYTES | Bus address |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data, valid the cycle after `busRdEn` |

## Verification
The bench targets the byte-boundary handoff on MISO. A design that shifts on the falling edge right after a load would drop the MSB of the header echo and of every read byte. It checks the N+1 filler rule: an off-by-one in the prefetch would return the data one address late, or would repeat the header. A burst that crosses 0x00FF and one that wraps past 0xFFFF would expose an increment that only touches the low byte. A foreign-ID transaction and an aborted header-plus-one-address transaction must leave the bus untouched. A block that decodes without matching, or that keeps its byte count across a chip-select release, would write stray bytes or misplace the next write.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic hdrLoad;     // capture received byte as header
    logic addrShift;   // shift received byte into address
    logic addrInc;     // step address by one
    logic txLoadHdr;   // load header echo into transmit shifter
    logic txLoadData;  // load prefetched read byte into transmit shifter
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    PH_HEADER,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_t;

endpackage

// File: rtl/spi_bridge_datapath.sv
module spi_bridge_datapath
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_BYTES  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  input  ctrlStrobes_t      str,
  input  logic              busRdEn,
  input  logic [7:0]        busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  output logic              rxDone,
  output logic [7:0]        rxData,
  output logic              csActive
);

  logic [SYNC_STAGES-1:0] sclkPipe, csnPipe, mosiPipe;
  logic sclkS, sclkPrev, mosiS, sclkRise, sclkFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csnPipe  <= '1;
      mosiPipe <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], spiSclk};
      csnPipe  <= {csnPipe[SYNC_STAGES-2:0], spiCsN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], spiMosi};
      sclkPrev <= sclkS;
    end
  end

  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign mosiS    = mosiPipe[SYNC_STAGES-1];
  assign csActive = ~csnPipe[SYNC_STAGES-1];
  assign sclkRise = csActive & sclkS & ~sclkPrev;
  assign sclkFall = csActive & ~sclkS & sclkPrev;

  // Receive side
  logic [2:0] bitCnt;
  logic [7:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN || !csActive) begin
      bitCnt  <= '0;
      rxShift <= '0;
      rxData  <= '0;
      rxDone  <= 1'b0;
    end else begin
      rxDone <= 1'b0;
      if (sclkRise) begin
        bitCnt  <= bitCnt + 3'd1;
        rxShift <= {rxShift[6:0], mosiS};
        if (bitCnt == 3'd7) begin
          rxData <= {rxShift[6:0], mosiS};
          rxDone <= 1'b1;
        end
      end
    end
  end

  // Header, address and read prefetch holding
  logic [7:0]        hdrReg, rdHold, txShift;
  logic [ADDR_W-1:0] addrReg, addrNext;
  logic              rdEnD1;

  generate
    if (ADDR_BYTES == 1) begin : g_addrOne
      assign addrNext = rxData;
    end else begin : g_addrMulti
      assign addrNext = {addrReg[ADDR_W-9:0], rxData};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || !csActive) begin
      hdrReg  <= '0;
      addrReg <= '0;
      rdHold  <= '0;
      rdEnD1  <= 1'b0;
    end else begin
      rdEnD1 <= busRdEn;
      if (str.hdrLoad)   hdrReg  <= rxData;
      if (str.addrShift) addrReg <= addrNext;
      else if (str.addrInc) addrReg <= addrReg + ADDR_W'(1);
      if (rdEnD1)        rdHold  <= busRdata;
    end
  end

  // Transmit side: no shift on the falling edge that closes a byte,
  // so a byte loaded at the boundary keeps its MSB on the line.
  always_ff @(posedge clk) begin
    if (!rstN || !csActive) begin
      txShift <= '0;
    end else if (str.txLoadHdr) begin
      txShift <= hdrReg;
    end else if (str.txLoadData) begin
      txShift <= rdHold;
    end else if (sclkFall && bitCnt != 3'd0) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign spiMiso  = csActive & txShift[7];
  assign busAddr  = addrReg;
  assign busWdata = rxData;

  // R1
  rx_after_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> $past(sclkRise));

  // R5
  echo_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.txLoadHdr |=> (!csActive || txShift == $past(hdrReg)));

endmodule

// File: rtl/spi_bridge_control.sv
module spi_bridge_control
  import spi_bridge_pkg::*;
#(
  parameter logic [6:0] TARGET_ID = 7'h2A,
  parameter int ADDR_BYTES        = 2,
  localparam int CNT_W            = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csActive,
  input  logic         rxDone,
  input  logic [7:0]   rxData,
  output ctrlStrobes_t str,
  output logic         busWrEn,
  output logic         busRdEn
);

  phase_t     state, nextState;
  logic [CNT_W-1:0] addrCnt, nextCnt;
  logic       isRead, rdPend, setRd, wrEn;

  always_comb begin
    str       = '0;
    wrEn      = 1'b0;
    setRd     = 1'b0;
    nextState = state;
    nextCnt   = addrCnt;
    if (rxDone) begin
      unique case (state)
        PH_HEADER: begin
          if (rxData[6:0] == TARGET_ID) begin
            str.hdrLoad = 1'b1;
            nextState   = PH_ADDR;
          end else begin
            nextState   = PH_SKIP;
          end
        end
        PH_ADDR: begin
          str.addrShift = 1'b1;
          if (addrCnt == CNT_W'(ADDR_BYTES - 1)) begin
            if (isRead) begin
              str.txLoadHdr = 1'b1;
              setRd         = 1'b1;
              nextState     = PH_READ;
            end else begin
              nextState     = PH_WRITE;
            end
          end else begin
            nextCnt = addrCnt + CNT_W'(1);
          end
        end
        PH_WRITE: begin
          wrEn        = 1'b1;
          str.addrInc = 1'b1;
        end
        PH_READ: begin
          str.txLoadData = 1'b1;
          str.addrInc    = 1'b1;
          setRd          = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !csActive) begin
      state   <= PH_HEADER;
      addrCnt <= '0;
      isRead  <= 1'b0;
      rdPend  <= 1'b0;
    end else begin
      state   <= nextState;
      addrCnt <= nextCnt;
      rdPend  <= setRd;
      if (str.hdrLoad) isRead <= rxData[7];
    end
  end

  assign busWrEn = wrEn;
  assign busRdEn = rdPend;

  // R10
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn));

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> !busRdEn);

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_SKIP) |=> (!busWrEn && !busRdEn));

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_bridge_pkg::*;
#(
  parameter logic [6:0] TARGET_ID = 7'h2A,
  parameter int ADDR_BYTES        = 2,
  parameter int SYNC_STAGES       = 2,
  localparam int ADDR_W           = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              busWrEn,
  output logic              busRdEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic [7:0]        busRdata
);

  ctrlStrobes_t str;
  logic         rxDone, csActive;
  logic [7:0]   rxData;

  spi_bridge_datapath #(
    .ADDR_BYTES (ADDR_BYTES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .str(str), .busRdEn(busRdEn), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata),
    .rxDone(rxDone), .rxData(rxData), .csActive(csActive)
  );

  spi_bridge_control #(
    .TARGET_ID (TARGET_ID),
    .ADDR_BYTES(ADDR_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csActive(csActive), .rxDone(rxDone), .rxData(rxData),
    .str(str), .busWrEn(busWrEn), .busRdEn(busRdEn)
  );

  // R4
  wr_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !spiCsN) |=> (busAddr == $past(busAddr) + ADDR_W'(1)));

endmodule

// File: tb/sim_spi_reg_bridge.sv
`timescale 1ns/1ps
module sim_spi_reg_bridge;

  localparam logic [6:0] ID = 7'h2A;
  localparam int HALF = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic spiMiso, busWrEn, busRdEn;
  logic [15:0] busAddr;
  logic [7:0]  busWdata;
  logic [7:0]  busRdata = 8'h00;

  spi_reg_bridge #(.TARGET_ID(ID), .ADDR_BYTES(2)) u0 (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata)
  );

  int checks = 0, errors = 0, busAccesses = 0;
  typedef struct { logic [15:0] a; logic [7:0] d; } wrItem_t;
  wrItem_t expQ[$];
  logic [7:0] mem [int];
  logic prevRd = 1'b0;

  function automatic logic [7:0] memVal(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard for writes, bus stub for reads
  always @(negedge clk) begin
    if (rstN) begin
      if (busWrEn || busRdEn) busAccesses++;
      if (busWrEn && busRdEn) check(0, "R10", "wr and rd together", 1, 0);
      if (prevRd && busRdEn) check(0, "R10", "rd pulse longer than 1", 1, 0);
      prevRd = busRdEn;
      if (busWrEn) begin
        if (expQ.size() == 0) begin
          check(0, "R4", "unexpected write addr", int'(busAddr), 0);
        end else begin
          wrItem_t e;
          e = expQ.pop_front();
          check(busAddr == e.a, "R4", "write addr", int'(busAddr), int'(e.a));
          check(busWdata == e.d, "R4", "write data", int'(busWdata), int'(e.d));
        end
        mem[int'(busAddr)] = busWdata;
      end
      if (busRdEn) busRdata = memVal(busAddr);
    end
  end

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i]   = spiMiso;
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
  endtask

  task automatic csStart;
    spiCsN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csEnd;
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendHead(input logic [7:0] hdr, input logic [15:0] addr);
    logic [7:0] rx;
    spiByte(hdr, rx);
    check(rx == 8'h00, "R9", "miso in header", int'(rx), 0);
    spiByte(addr[15:8], rx);
    check(rx == 8'h00, "R9", "miso in addr hi", int'(rx), 0);
    spiByte(addr[7:0], rx);
    check(rx == 8'h00, "R9", "miso in addr lo", int'(rx), 0);
  endtask

  task automatic writeBurst(input logic [6:0] id, input logic [15:0] addr,
                            input int n, input logic [7:0] seed, input bit ack);
    logic [7:0] rx;
    csStart();
    sendHead({1'b0, id}, addr);
    for (int k = 0; k < n; k++) begin
      wrItem_t e;
      e.a = addr + 16'(k);
      e.d = seed + 8'(k * 7);
      if (ack) expQ.push_back(e);
      spiByte(e.d, rx);
      check(rx == 8'h00, ack ? "R9" : "R2", "miso in write data", int'(rx), 0);
    end
    csEnd();
  endtask

  task automatic readBurst(input logic [6:0] id, input logic [15:0] addr,
                           input int n, input bit ack);
    logic [7:0] rx, exp;
    csStart();
    sendHead({1'b1, id}, addr);
    spiByte(8'hFF, rx);
    exp = ack ? {1'b1, id} : 8'h00;
    check(rx == exp, ack ? "R5" : "R2", "header echo", int'(rx), int'(exp));
    for (int k = 0; k < n; k++) begin
      spiByte(8'hFF, rx);
      exp = ack ? memVal(addr + 16'(k)) : 8'h00;
      check(rx == exp, ack ? "R6" : "R2", "read data", int'(rx), int'(exp));
    end
    csEnd();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0] rx;
    int snap;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(spiMiso == 1'b0, "R9", "reset miso", int'(spiMiso), 0);
    check(!busWrEn && !busRdEn, "R10", "reset strobes", int'({busWrEn, busRdEn}), 0);

    // R1 R3 R4: plain write burst then read back (R5 R6)
    writeBurst(ID, 16'h0010, 4, 8'h11, 1);
    check(expQ.size() == 0, "R4", "writes outstanding", expQ.size(), 0);
    readBurst(ID, 16'h0010, 4, 1);
    readBurst(ID, 16'h0200, 2, 1);

    // R2: foreign ID, write and read, no access and silent line
    snap = busAccesses;
    writeBurst(7'h15, 16'h0010, 3, 8'h99, 0);
    readBurst(7'h15, 16'h0010, 3, 0);
    check(busAccesses == snap, "R2", "bus accesses on foreign id", busAccesses, snap);
    readBurst(ID, 16'h0010, 3, 1);

    // R7: long burst across a byte carry
    writeBurst(ID, 16'h00F8, 20, 8'h40, 1);
    readBurst(ID, 16'h00F8, 20, 1);

    // R8: abort mid-address, next transaction starts fresh
    snap = busAccesses;
    csStart();
    spiByte({1'b0, ID}, rx);
    spiByte(8'h12, rx);
    csEnd();
    check(busAccesses == snap, "R8", "access after abort", busAccesses, snap);
    writeBurst(ID, 16'h1234, 1, 8'hC3, 1);
    readBurst(ID, 16'h1234, 1, 1);

    // R7: wrap at the top of the address range
    writeBurst(ID, 16'hFFFE, 4, 8'h07, 1);
    readBurst(ID, 16'hFFFE, 4, 1);

    check(expQ.size() == 0, "R4", "writes outstanding at end", expQ.size(), 0);
    check(spiMiso == 1'b0, "R9", "idle miso", int'(spiMiso), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule